// File: doc/BRIEF.md
# Serial Adjustment Register Slave

This block is a two-wire serial-bus slave. It keeps a bank of byte-wide adjustment registers for a display-control device and presents them as parallel outputs. A host controller sets the registers by writing to the device address. The first byte after the address picks a register, and each following byte lands in the next register. When the host reads from the device address, it gets back one status byte built from live status inputs. A read carries no register selection.

The bus lines are sampled by a fast system clock. Each line passes through a two-flop synchronizer and a qualification counter, so short spikes never reach the protocol logic. The slave never drives SCL. It drives SDA only by asserting an open-drain pull-down enable. There is no data stream at the block's edge: the register outputs are level signals that change one clock after a write byte is accepted, and the status inputs are plain levels captured when a reply starts.

Top module: `i2c_adj_slave`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR (default 7'h46, so 0x8C for a write and 0x8D for a read) is acknowledged by pulling SDA low through the ninth clock of that byte.
- R2: In a write transfer, the byte after the address is the register subaddress and the byte after that is stored in that register. Each of these bytes is acknowledged, and the register output shows the new value.
- R3: Further data bytes in the same transfer, with no stop or start between them, go to successive subaddresses, one higher per byte.
- R4: After register NUM_REGS-1 (default 15), the subaddress wraps to 0. A data byte sent to a subaddress of NUM_REGS or more is acknowledged but not stored, and the next byte goes to subaddress 0.
- R5: In a read transfer, the slave sends one status byte MSB first: bit7 h_lock, bit6 v_lock, bit5 xray_latched, bit4 h_pol, bit3 v_pol, bits2..0 sync_seen. It changes SDA only while SCL is low.
- R6: After the eighth reply bit, the slave releases SDA and ignores further clocks until the next start or stop, whatever the host acknowledges. Bytes clocked in that time read as 0xFF.
- R7: A transfer to any other address gets no acknowledge, and no register changes until the next start.
- R8: A stop releases SDA and returns the slave to idle. A byte cut off by a stop or start before its eighth bit is discarded and written nowhere.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks (default 10, which is 50 ns at 200 MHz) has no effect on the transfer.
- R10: A synchronous reset clears every register to 0, releases SDA and returns the bus logic to idle.
- R11: A repeated start in the middle of a transfer begins a new transfer, which starts with an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain) |
| h_lock | input | 1 | Horizontal lock status |
| v_lock | input | 1 | Vertical lock status |
| xray_latched | input | 1 | X-ray protection latched status |
| h_pol | input | 1 | Detected horizontal polarity |
| v_pol | input | 1 | Detected vertical polarity |
| sync_seen | input | 3 | Sync detection flags |
| regs_flat | output | NUM_REGS*8 | Register contents, register i at bits [i*8+7:i*8] |

## Verification
The hardest states to reach from the ports lie inside the filter window. One is a sub-threshold SDA dip while SCL is high, which an unfiltered slave would decode as a start followed by a stop. The other is a short SCL spike while SCL is low, which would shift in an extra bit. The bench's bit task can insert either pulse, a few clocks long, in the middle of a data byte. The stored value then shows whether the filter absorbed it. The silent state after the reply is reached by having the host acknowledge the status byte and clock a second byte, and the bench checks that the bus stays high throughout.

// File: rtl/i2c_adj_pkg.sv
package i2c_adj_pkg;
  localparam int SUB_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_IGNORE
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } byte_phase_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int FILT_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic             sync1, sync2;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      clean_o <= 1'b1;
      run_cnt <= '0;
    end else begin
      sync1 <= raw_i;
      sync2 <= sync1;
      if (sync2 == clean_o) begin
        run_cnt <= '0;
      end else if (run_cnt == CNT_LAST) begin
        clean_o <= sync2;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // the qualified level only ever moves to a level the synchronizer was holding
  AST_FILTER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (clean_o != $past(clean_o)) |-> (clean_o == $past(sync2))); // R9
endmodule

// File: rtl/i2c_adj_regbank.sv
module i2c_adj_regbank #(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_flat[i*8 +: 8] <= 8'h00;
      end else if (wr_en && (wr_addr == 8'(i))) begin
        regs_flat[i*8 +: 8] <= wr_data;
      end
    end
  end

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_addr) < NUM_REGS)); // R4
endmodule

// File: rtl/i2c_adj_engine.sv
module i2c_adj_engine
  import i2c_adj_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h46,
  parameter int         NUM_REGS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic [7:0]       status,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [SUB_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NUM_REGS - 1);

  bus_state_t       state;
  byte_phase_t      phase;
  logic             scl_q, sda_q;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             byte_full;
  logic             is_read;
  logic [SUB_W-1:0] ptr;

  logic start_det, stop_det, scl_rise, scl_fall;

  always_comb begin
    start_det = scl_f & scl_q & sda_q & ~sda_f;
    stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    scl_rise  = scl_f & ~scl_q;
    scl_fall  = ~scl_f & scl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_full <= 1'b0;
      is_read   <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (stop_det) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        byte_full <= 1'b0;
      end else if (start_det) begin
        state     <= ST_RX;
        phase     <= PH_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && !byte_full) begin
              shreg   <= {shreg[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              unique case (phase)
                PH_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    is_read <= shreg[0];
                    sda_oe  <= 1'b1;
                    state   <= ST_ACK;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                PH_SUB: begin
                  ptr    <= shreg;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
                default: begin
                  if (32'(ptr) < NUM_REGS) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= shreg;
                  end
                  ptr    <= (ptr >= LAST_SUB) ? '0 : ptr + 1'b1;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (phase == PH_ADDR && is_read) begin
                shreg  <= status;
                sda_oe <= ~status[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
                if (phase == PH_ADDR) phase <= PH_SUB;
                else                  phase <= PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_IGNORE;
              end else begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_oe  <= ~shreg[6];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R8

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det))
      |-> !$past(scl_f)); // R5

  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RX && phase == PH_ADDR && scl_fall && byte_full
      && shreg[7:1] != DEV_ADDR) |=> !sda_oe); // R7

  AST_IGNORE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |=> !wr_en); // R6
endmodule

// File: rtl/i2c_adj_slave.sv
module i2c_adj_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h46,
  parameter int         NUM_REGS = 16,
  parameter int         FILT_LEN = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  h_lock,
  input  logic                  v_lock,
  input  logic                  xray_latched,
  input  logic                  h_pol,
  input  logic                  v_pol,
  input  logic [2:0]            sync_seen,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic [7:0]        status_byte;
  logic              wr_en;
  logic [7:0]        wr_addr, wr_data;

  assign raw_lines   = {sda_i, scl_i};
  assign status_byte = {h_lock, v_lock, xray_latched, h_pol, v_pol, sync_seen};

  for (genvar k = 0; k < NLINES; k++) begin : g_filt
    i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (raw_lines[k]),
      .clean_o (clean_lines[k])
    );
  end

  i2c_adj_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (clean_lines[0]),
    .sda_f   (clean_lines[1]),
    .status  (status_byte),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  i2c_adj_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .regs_flat (regs_flat)
  );

  AST_RESET_RELEASED: assert property (@(posedge clk)
    rst |=> !sda_oe); // R10
endmodule

// File: tb/tb_i2c_adj_slave.sv
module tb_i2c_adj_slave;
  localparam int NUM_REGS = 16;
  localparam int Q        = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_oe;
  logic h_lock = 0, v_lock = 0, xray_latched = 0, h_pol = 0, v_pol = 0;
  logic [2:0] sync_seen = 3'b000;
  logic [NUM_REGS*8-1:0] regs_flat;
  logic sda_bus;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] model [NUM_REGS];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_drv & ~sda_oe;

  i2c_adj_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_bus), .sda_oe(sda_oe),
    .h_lock(h_lock), .v_lock(v_lock), .xray_latched(xray_latched),
    .h_pol(h_pol), .v_pol(v_pol), .sync_seen(sync_seen), .regs_flat(regs_flat)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NUM_REGS; i++) begin
      n_chk++;
      if (regs_flat[i*8 +: 8] !== model[i]) begin
        n_fail++;
        $display("FAIL %s: reg %0d actual %h expected %h", req, i,
                 regs_flat[i*8 +: 8], model[i]);
      end
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic bus_start();
    sda_drv = 1; wait_clk(Q);
    scl_drv = 1; wait_clk(Q);
    sda_drv = 0; wait_clk(Q);
    scl_drv = 0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 0; wait_clk(Q);
    scl_drv = 1; wait_clk(Q);
    sda_drv = 1; wait_clk(Q);
  endtask

  // glitch: 0 none, 1 short SCL spike in a low phase, 2 short SDA dip while SCL high
  task automatic put_bit(input logic b, input int glitch, output logic seen);
    sda_drv = b;
    wait_clk(Q / 2);
    if (glitch == 1) begin scl_drv = 1; wait_clk(5); scl_drv = 0; end
    wait_clk(Q / 2 - ((glitch == 1) ? 5 : 0));
    scl_drv = 1; wait_clk(Q);
    seen = sda_bus;
    if (glitch == 2) begin sda_drv = 0; wait_clk(5); sda_drv = b; wait_clk(Q - 5); end
    else wait_clk(Q);
    scl_drv = 0; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, input int glitch, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(d[i], (i == 4) ? glitch : 0, s);
    put_bit(1'b1, 0, s);
    acked = ~s;
  endtask

  task automatic send_bits(input logic [7:0] d, input int nbits);
    logic s;
    for (int i = 7; i > 7 - nbits; i--) put_bit(d[i], 0, s);
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin put_bit(1'b1, 0, s); d[i] = s; end
    put_bit(~master_ack, 0, s);
  endtask

  task automatic write_burst(input logic [7:0] sub, input logic [7:0] data[$],
                             input string req);
    logic a;
    bus_start();
    send_byte(8'h8C, 0, a); check({req, " R1 addr ack"}, a, 1);
    send_byte(sub, 0, a);   check({req, " R2 sub ack"}, a, 1);
    foreach (data[i]) begin
      send_byte(data[i], 0, a); check({req, " R2 data ack"}, a, 1);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    check("R10 sda released", sda_oe, 0);
    for (int i = 0; i < NUM_REGS; i++) model[i] = 8'h00;
    check_regs("R10 regs cleared");
  endtask

  task automatic t_single_write();
    write_burst(8'h03, '{8'hA5}, "single");
    model[3] = 8'hA5;
    check_regs("R2 single write");
    check("R8 released after stop", sda_oe, 0);
  endtask

  task automatic t_burst_wrap();
    write_burst(8'h0E, '{8'h11, 8'h22, 8'h33, 8'h44}, "burst");
    model[14] = 8'h11; model[15] = 8'h22; model[0] = 8'h33; model[1] = 8'h44;
    check_regs("R3 R4 burst with wrap");
  endtask

  task automatic t_unimplemented();
    write_burst(8'h20, '{8'h77, 8'h66}, "unimpl");
    model[0] = 8'h66;
    check_regs("R4 out-of-range ignored, next goes to 0");
  endtask

  task automatic t_foreign();
    logic a;
    bus_start();
    send_byte(8'h90, 0, a); check("R7 no ack foreign addr", a, 0);
    send_byte(8'h05, 0, a); check("R7 no ack after foreign", a, 0);
    send_byte(8'h5A, 0, a); check("R7 no ack data", a, 0);
    bus_stop();
    check_regs("R7 regs untouched");
  endtask

  task automatic t_read(input logic [7:0] st);
    logic a;
    logic [7:0] d;
    {h_lock, v_lock, xray_latched, h_pol, v_pol, sync_seen} = st;
    bus_start();
    send_byte(8'h8D, 0, a); check("R1 read addr ack", a, 1);
    read_byte(1'b0, d);     check("R5 status byte", d, st);
    bus_stop();
  endtask

  task automatic t_after_reply();
    logic a;
    logic [7:0] d;
    {h_lock, v_lock, xray_latched, h_pol, v_pol, sync_seen} = 8'h00;
    bus_start();
    send_byte(8'h8D, 0, a); check("R1 read addr ack", a, 1);
    read_byte(1'b1, d);     check("R5 all-zero status", d, 8'h00);
    read_byte(1'b1, d);     check("R6 released after reply", d, 8'hFF);
    send_byte(8'h07, 0, a); check("R6 no ack after reply", a, 0);
    bus_stop();
    check_regs("R6 regs untouched");
  endtask

  task automatic t_partial();
    logic a;
    bus_start();
    send_byte(8'h8C, 0, a); check("R8 addr ack", a, 1);
    send_byte(8'h05, 0, a); check("R8 sub ack", a, 1);
    send_bits(8'hF0, 4);
    scl_drv = 0; wait_clk(Q);
    bus_stop();
    check("R8 released", sda_oe, 0);
    check_regs("R8 partial byte discarded");
  endtask

  task automatic t_restart();
    logic a;
    bus_start();
    send_byte(8'h8C, 0, a); check("R11 addr ack", a, 1);
    send_byte(8'h07, 0, a); check("R11 sub ack", a, 1);
    bus_start();
    send_byte(8'h8C, 0, a); check("R11 addr ack after restart", a, 1);
    send_byte(8'h08, 0, a); check("R11 new sub ack", a, 1);
    send_byte(8'h5A, 0, a); check("R11 data ack", a, 1);
    bus_stop();
    model[8] = 8'h5A;
    check_regs("R11 restart write");
  endtask

  task automatic t_glitch();
    logic a;
    bus_start();
    send_byte(8'h8C, 0, a); check("R9 addr ack", a, 1);
    send_byte(8'h09, 0, a); check("R9 sub ack", a, 1);
    send_byte(8'h5C, 1, a); check("R9 ack with SCL spike", a, 1);
    send_byte(8'hD8, 2, a); check("R9 ack with SDA dip", a, 1);
    bus_stop();
    model[9] = 8'h5C; model[10] = 8'hD8;
    check_regs("R9 glitches rejected");
  endtask

  task automatic t_reset_mid();
    logic a;
    bus_start();
    send_byte(8'h8C, 0, a);
    send_byte(8'h02, 0, a);
    rst = 1; wait_clk(4); rst = 0; wait_clk(2);
    check("R10 sda released on reset", sda_oe, 0);
    for (int i = 0; i < NUM_REGS; i++) model[i] = 8'h00;
    check_regs("R10 regs cleared mid-transfer");
    bus_stop();
  endtask

  initial begin
    wait_clk(200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    wait_clk(10);
    rst = 0;
    wait_clk(4);
    t_reset();
    t_single_write();
    t_burst_wrap();
    t_unimplemented();
    t_foreign();
    t_read(8'b1010_0110);
    t_read(8'b0101_1001);
    t_after_reply();
    t_partial();
    t_restart();
    t_glitch();
    t_reset_mid();
    finish_up();
  end
endmodule